// File: doc/BRIEF.md
# Circular Interrupt Event Queue Writer

This block takes exception events from a set of channels and records each one as a 32-bit entry in a circular queue. The queue sits in a word-addressed memory that is shared with host software. Each event carries a channel index and a group of exception flags. The block first reads the slot at its write pointer. If the slot is free, it writes the event back into the same slot with the valid bit set, then moves the pointer forward. The queue has no depth register. Its last slot is the one whose wrap bit the host set in memory beforehand. After filling that slot, the pointer returns to the configured base address.

The block does not raise a host interrupt on every posted entry. A down counter, loaded from a programmable threshold, raises a sticky global-interrupt flag once per threshold's worth of posted entries. When the slot at the pointer is still valid, the queue is full. The event is then dropped and a sticky overflow flag is raised. The host clears either flag by writing a one to its clear input, and it can load the write pointer while the block is idle.

Events arrive over a valid/ready handshake and are handled one at a time. Each event takes three cycles from acceptance to completion.

Top module: `irq_ring_poster`

## Requirements
- R1: `ev_ready` is high only when the block is idle and `ptr_load` is low. An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` then stays low for the next two cycles (read and decide) and returns high in the cycle after that.
- R2: In the cycle after acceptance, the block asserts `mem_rd_en` with `mem_addr` equal to the write pointer. The memory returns `mem_rdata` one cycle later, and the block makes its decision in that cycle.
- R3: In the decide cycle, if the bit 31 (valid) of the slot read is 0, the block asserts `mem_wr_en` to the same address. The word written is: bit 31 = 1, bit 30 = the wrap bit just read, bits [16+FW-1:16] = event flags, bits [CHW-1:0] = channel index, and all other bits 0.
- R4: After a write where the wrap bit read was 0, `ptr_out` equals the old pointer plus one (modulo 2^AW) from the next cycle on.
- R5: After a write where the wrap bit read was 1, `ptr_out` equals `cfg_base` as sampled in the decide cycle.
- R6: If the slot read has bit 31 = 1, nothing is written, the pointer and the coalescing counter are unchanged, and `ovf` is high from the next cycle on.
- R7: Every posted entry decrements the coalescing counter. When the count reaches zero, `gint` goes high in the next cycle and the counter is reloaded. The effective threshold is `cfg_thresh`, with 0 treated as 1. It is sampled when the counter loads (on the first post after reset and at every reload).
- R8: `gint` and `ovf` hold until cleared by a one on `clr_gint` / `clr_ovf`, which takes effect in the next cycle. A set condition in the same cycle as a clear leaves the flag high.
- R9: A `ptr_load` pulse while idle loads `ptr_load_val` into the pointer, visible in the next cycle. While an event is in progress, `ptr_load` is ignored.
- R10: After reset, `ev_ready` is 1, and `ptr_out`, `gint` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Queue base word address |
| cfg_thresh | input | CW | Interrupt coalescing threshold |
| ptr_load | input | 1 | Load write pointer (honoured when idle) |
| ptr_load_val | input | AW | Value for pointer load |
| ptr_out | output | AW | Current write pointer |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Block can accept an event |
| ev_chan | input | CHW | Event channel index |
| ev_flags | input | FW | Event exception flags |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after read strobe |
| clr_gint | input | 1 | Write-one-to-clear for gint |
| clr_ovf | input | 1 | Write-one-to-clear for ovf |
| gint | output | 1 | Sticky global interrupt |
| ovf | output | 1 | Sticky queue-overflow flag |

## Verification
The delicate coincidence is a flag being set and cleared in the same cycle. This happens when an entry is posted that empties the counter, or when a full slot is found, while the host asserts the matching clear. The bench provokes it by holding `clr_gint` and `clr_ovf` high every cycle through a window in which events keep posting and the queue fills. It also drives a threshold of zero there, so every post sets `gint`. A cycle-by-cycle model decides each such cycle with set-wins priority, and both flags are compared on every clock.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;
    localparam int unsigned ENT_W    = 32;
    localparam int unsigned V_POS    = 31;
    localparam int unsigned W_POS    = 30;
    localparam int unsigned FLAG_POS = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_DECIDE = 2'd2
    } seq_st_e;
endpackage

// File: rtl/irq_ring_seq.sv
module irq_ring_seq
    import irq_ring_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned CHW = 8,
    parameter int unsigned FW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cfg_base,
    input  logic             ptr_load,
    input  logic [AW-1:0]    ptr_load_val,
    input  logic             ev_valid,
    output logic             ev_ready,
    input  logic [CHW-1:0]   ev_chan,
    input  logic [FW-1:0]    ev_flags,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_addr,
    output logic [ENT_W-1:0] mem_wdata,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic [AW-1:0]    ptr_out,
    output logic             post,
    output logic             drop
);
    typedef struct packed {
        seq_st_e        st;
        logic [AW-1:0]  ptr;
        logic [CHW-1:0] chan;
        logic [FW-1:0]  flags;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d         = q;
        ev_ready  = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = q.ptr;
        mem_wdata = '0;
        post      = 1'b0;
        drop      = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                ev_ready = !ptr_load;
                if (ptr_load) begin
                    d.ptr = ptr_load_val;
                end else if (ev_valid) begin
                    d.chan  = ev_chan;
                    d.flags = ev_flags;
                    d.st    = ST_READ;
                end
            end
            ST_READ: begin
                mem_rd_en = 1'b1;
                d.st      = ST_DECIDE;
            end
            ST_DECIDE: begin
                d.st = ST_IDLE;
                if (mem_rdata[V_POS]) begin
                    drop = 1'b1;
                end else begin
                    mem_wr_en                  = 1'b1;
                    mem_wdata[V_POS]           = 1'b1;
                    mem_wdata[W_POS]           = mem_rdata[W_POS];
                    mem_wdata[FLAG_POS +: FW]  = q.flags;
                    mem_wdata[CHW-1:0]         = q.chan;
                    post                       = 1'b1;
                    d.ptr = mem_rdata[W_POS] ? cfg_base : q.ptr + AW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ptr: '0, chan: '0, flags: '0};
        end else begin
            q <= d;
        end
    end

    assign ptr_out = q.ptr;
endmodule

// File: rtl/irq_ring_coalesce.sv
module irq_ring_coalesce #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_thresh,
    input  logic          post,
    output logic          hit
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } coal_t;

    coal_t q, d;
    logic [CW-1:0] eff_thr;
    logic [CW-1:0] cur;

    always_comb begin
        d       = q;
        hit     = 1'b0;
        eff_thr = (cfg_thresh == '0) ? CW'(1) : cfg_thresh;
        // zero count means the counter has not been loaded since reset
        cur     = (q.cnt == '0) ? eff_thr : q.cnt;
        if (post) begin
            if (cur == CW'(1)) begin
                hit   = 1'b1;
                d.cnt = eff_thr;
            end else begin
                d.cnt = cur - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/irq_ring_sticky.sv
module irq_ring_sticky #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    typedef struct packed {
        logic [N-1:0] flg;
    } stk_t;

    stk_t q, d;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // set wins over a clear in the same cycle
        assign d.flg[g] = set[g] | (q.flg[g] & ~clr[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{flg: '0};
        end else begin
            q <= d;
        end
    end

    assign flag = q.flg;
endmodule

// File: rtl/irq_ring_poster.sv
module irq_ring_poster
    import irq_ring_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned CHW = 8,
    parameter int unsigned FW  = 8,
    parameter int unsigned CW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cfg_base,
    input  logic [CW-1:0]    cfg_thresh,
    input  logic             ptr_load,
    input  logic [AW-1:0]    ptr_load_val,
    output logic [AW-1:0]    ptr_out,
    input  logic             ev_valid,
    output logic             ev_ready,
    input  logic [CHW-1:0]   ev_chan,
    input  logic [FW-1:0]    ev_flags,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_addr,
    output logic [ENT_W-1:0] mem_wdata,
    input  logic [ENT_W-1:0] mem_rdata,
    input  logic             clr_gint,
    input  logic             clr_ovf,
    output logic             gint,
    output logic             ovf
);
    localparam int unsigned NFLAG = 2;

    logic post, drop, hit;
    logic [NFLAG-1:0] fl_set, fl_clr, fl_q;

    irq_ring_seq #(.AW(AW), .CHW(CHW), .FW(FW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_base     (cfg_base),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ev_valid     (ev_valid),
        .ev_ready     (ev_ready),
        .ev_chan      (ev_chan),
        .ev_flags     (ev_flags),
        .mem_rd_en    (mem_rd_en),
        .mem_wr_en    (mem_wr_en),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .ptr_out      (ptr_out),
        .post         (post),
        .drop         (drop)
    );

    irq_ring_coalesce #(.CW(CW)) u_coal (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_thresh (cfg_thresh),
        .post       (post),
        .hit        (hit)
    );

    assign fl_set = {drop, hit};
    assign fl_clr = {clr_ovf, clr_gint};

    irq_ring_sticky #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (fl_clr),
        .flag  (fl_q)
    );

    assign gint = fl_q[0];
    assign ovf  = fl_q[1];
endmodule

// File: rtl/irq_ring_poster_chk.sv
module irq_ring_poster_chk
    import irq_ring_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    cfg_base,
    input logic [AW-1:0]    ptr_out,
    input logic             ev_valid,
    input logic             ev_ready,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic [AW-1:0]    mem_addr,
    input logic [ENT_W-1:0] mem_wdata,
    input logic [ENT_W-1:0] mem_rdata,
    input logic             clr_gint,
    input logic             clr_ovf,
    input logic             gint,
    input logic             ovf
);
    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_ready);

    // R2
    write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));

    // R2
    no_rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R3
    valid_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wdata[V_POS]);

    // R3
    wrap_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wdata[W_POS] == mem_rdata[W_POS]);

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !mem_rdata[W_POS]) |=> ptr_out == $past(mem_addr) + AW'(1));

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_rdata[W_POS]) |=> ptr_out == $past(cfg_base));

    // R6
    full_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_rd_en) && mem_rdata[V_POS]) |-> !mem_wr_en);

    // R6
    full_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_rd_en) && mem_rdata[V_POS]) |=> ovf);

    // R8
    gint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gint && !clr_gint) |=> gint);

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);
endmodule

bind irq_ring_poster irq_ring_poster_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_base  (cfg_base),
    .ptr_out   (ptr_out),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .clr_gint  (clr_gint),
    .clr_ovf   (clr_ovf),
    .gint      (gint),
    .ovf       (ovf)
);

// File: tb/irq_ring_poster_bench.sv
`timescale 1ns/1ps
module irq_ring_poster_bench;
    localparam int AW = 16, CHW = 8, FW = 8, CW = 8;
    localparam int NCYC = 2600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_thresh = '0;
    logic          ptr_load = 1'b0;
    logic [AW-1:0] ptr_load_val = '0;
    logic [AW-1:0] ptr_out;
    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [CHW-1:0] ev_chan = '0;
    logic [FW-1:0] ev_flags = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          clr_gint = 1'b0, clr_ovf = 1'b0;
    logic          gint, ovf;

    logic [31:0] mem [0:63];

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    int          m_phase = 0;
    logic [AW-1:0] m_ptr = '0;
    int          m_rem = 0;
    bit          m_gint = 0, m_ovf = 0;
    logic [CHW-1:0] m_chan = '0;
    logic [FW-1:0] m_flags = '0;
    logic [31:0] m_slot = '0;
    bit          taken = 0;

    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    irq_ring_poster #(.AW(AW), .CHW(CHW), .FW(FW), .CW(CW)) u_irq_ring_poster (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_thresh(cfg_thresh),
        .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_out(ptr_out),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_chan(ev_chan), .ev_flags(ev_flags),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .clr_gint(clr_gint), .clr_ovf(clr_ovf), .gint(gint), .ovf(ovf)
    );

    // memory environment: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[5:0]];
        if (mem_wr_en) mem[mem_addr[5:0]] <= mem_wdata;
    end

    function automatic int eff(input logic [CW-1:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        bit set_g, set_o;
        set_g = 0; set_o = 0; taken = 0;
        if (!rst_n) begin
            m_phase = 0; m_ptr = '0; m_rem = 0; m_gint = 0; m_ovf = 0;
        end else begin
            if (m_phase == 0) begin
                if (ptr_load) m_ptr = ptr_load_val;
                else if (ev_valid) begin
                    m_chan = ev_chan; m_flags = ev_flags; m_phase = 1; taken = 1;
                end
            end else if (m_phase == 1) begin
                m_slot = mem[m_ptr[5:0]];
                m_phase = 2;
            end else begin
                m_phase = 0;
                if (m_slot[31]) set_o = 1;
                else begin
                    if (m_rem == 0) m_rem = eff(cfg_thresh);
                    m_rem = m_rem - 1;
                    if (m_rem == 0) begin set_g = 1; m_rem = eff(cfg_thresh); end
                    m_ptr = m_slot[30] ? cfg_base : m_ptr + 1;
                end
            end
            m_gint = set_g ? 1 : (clr_gint ? 0 : m_gint);
            m_ovf  = set_o ? 1 : (clr_ovf ? 0 : m_ovf);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [31:0] ew;
        bit exp_rdy, exp_wr;
        exp_rdy = (m_phase == 0) && !ptr_load;
        exp_wr  = (m_phase == 2) && !m_slot[31];
        ew = '0;
        ew[31] = 1'b1; ew[30] = m_slot[30]; ew[23:16] = m_flags; ew[7:0] = m_chan;
        chk(ev_ready == exp_rdy, "R1 ev_ready", 32'(ev_ready), 32'(exp_rdy));
        chk(mem_rd_en == (m_phase == 1), "R2 mem_rd_en", 32'(mem_rd_en), 32'(m_phase == 1));
        if (m_phase == 1) chk(mem_addr == m_ptr, "R2 read addr", 32'(mem_addr), 32'(m_ptr));
        chk(mem_wr_en == exp_wr, "R3 R6 mem_wr_en", 32'(mem_wr_en), 32'(exp_wr));
        if (exp_wr) begin
            chk(mem_wdata == ew, "R3 write data", mem_wdata, ew);
            chk(mem_addr == m_ptr, "R3 write addr", 32'(mem_addr), 32'(m_ptr));
        end
        chk(ptr_out == m_ptr, "R4 R5 R9 ptr_out", 32'(ptr_out), 32'(m_ptr));
        chk(gint == m_gint, "R7 R8 gint", 32'(gint), 32'(m_gint));
        chk(ovf == m_ovf, "R6 R8 ovf", 32'(ovf), 32'(m_ovf));
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic drain(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) mem[i][31] = 1'b0;
    endtask

    initial begin
        int lo, hi;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[15][30] = 1'b1;          // ring A: 8..15
        mem[36][30] = 1'b1;          // ring B: 32..36
        lo = 8; hi = 15;
        cfg_base = 16'd8; cfg_thresh = 8'd3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(ev_ready == 1'b1, "R10 ready after reset", 32'(ev_ready), 1);
        chk(ptr_out == '0, "R10 ptr after reset", 32'(ptr_out), 0);
        chk(gint == 1'b0 && ovf == 1'b0, "R10 flags after reset", {30'd0, ovf, gint}, 0);
        for (int k = 0; k < NCYC; k++) begin
            if (k > 0) @(negedge clk);
            compare();
            lfsr = step(lfsr);
            // thresholds: R7 including zero-as-one
            if (k == 700)  cfg_thresh = 8'd0;
            if (k == 1000) cfg_thresh = 8'd5;
            if (k == 1500) begin cfg_base = 16'd32; lo = 32; hi = 36; cfg_thresh = 8'd2; end
            if (k == 2100) cfg_thresh = 8'd0;
            // pointer loads, R9 (also while busy)
            ptr_load = 1'b0;
            if (k == 2 || (k >= 1500 && k < 1506)) begin
                ptr_load = 1'b1; ptr_load_val = AW'(lo);
            end else if (lfsr[11:6] == 6'd5) begin
                ptr_load = 1'b1; ptr_load_val = AW'(lo + int'(lfsr[20:16]) % (hi - lo + 1));
            end
            // events
            if (taken || !ev_valid) begin
                ev_valid = (k > 4) && !(k >= 1500 && k < 1506) && (lfsr[2:0] != 3'd0);
                ev_chan  = lfsr[15:8];
                ev_flags = lfsr[27:20];
            end
            // host draining; starved windows force overflow (R6)
            if (!((k > 300 && k < 500) || (k > 1150 && k < 1350) || (k > 1900 && k < 2000))
                && lfsr[7:4] == 4'd0)
                drain(lo, hi);
            // clears; windows of constant clear to collide with sets (R8)
            if ((k > 1200 && k < 1300) || (k > 2150 && k < 2250)) begin
                clr_gint = 1'b1; clr_ovf = 1'b1;
            end else begin
                clr_gint = gint && lfsr[9];
                clr_ovf  = ovf && lfsr[13:12] == 2'd0;
            end
        end
        @(negedge clk);
        compare();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule